// File: doc/BRIEF.md
# Buffer Low Watermark Tracker

This block watches a circular line cache while an output frame is produced. On each cycle it takes a write position and a read position, plus the index of the output line in progress. The occupancy is the distance from the read position forward to the write position, taken modulo the cache size. Over one frame the block keeps the smallest occupancy it saw and the output line where that smallest value first occurred.

When the next frame starts, the block publishes both values as one 32-bit status word and starts a fresh search. It also counts cache block loads. Each load fetches a 16 by 8 pixel block, 128 pixels in total. The count for each completed frame is published at the same boundary.

A stall flag is raised combinationally whenever the two positions coincide. A published minimum of zero means that the consumer caught up with the producer at some point in that frame. A nonzero published minimum shows how much headroom the cache had. The cache memory and the logic that produces the positions live elsewhere.

Top module: `wm_tracker`

## Requirements
- R1: The occupancy is (write position - read position) modulo 2^PTR_W, so a write position that has wrapped past zero still gives the correct positive distance.
- R2: `stall` is 1 in the same cycle, with no register in the path, exactly when the write position equals the read position. Otherwise it is 0.
- R3: Bits [15:0] of `run_status` give the lowest occupancy among the qualified samples of the previous frame, zero-extended. A value of 0 there marks a frame in which the cache ran empty.
- R4: Bits [31:16] of `run_status` give the output line of the sample that set that minimum. When samples tie, the earliest one is kept.
- R5: A cycle with `frame_start` high publishes the finished frame's values on the next clock edge. That cycle's own sample and load count toward the new frame.
- R6: A frame with no qualified sample publishes 16'hFFFF in bits [15:0] and 0 in bits [31:16].
- R7: A sample taken while `sample_valid` is low has no effect on the published minimum or line.
- R8: `load_count` gives the number of cycles with `cache_load` high during the previous frame.
- R9: The load counter saturates at 2^CNT_W-1 and does not wrap.
- R10: After reset, `run_status` is 32'h0000FFFF and `load_count` is 0. Both outputs change only on the edge after a `frame_start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking the first cycle of a frame |
| sample_valid | input | 1 | Qualifies the positions and line for the minimum search |
| wr_pos | input | PTR_W | Cache write position |
| rd_pos | input | PTR_W | Cache read position |
| out_line | input | 16 | Output line index of the current access |
| cache_load | input | 1 | One cycle per cache block load |
| run_status | output | 32 | {line of minimum, minimum occupancy} for the previous frame |
| load_count | output | CNT_W | Cache loads in the previous frame |
| stall | output | 1 | Current occupancy is zero |

## Verification
A running minimum or line register that takes a wrong value cannot be seen right away. It shows up only in `run_status`, one edge after the next `frame_start`, so every test closes its frame before it checks anything. A wrong modular subtraction changes `stall` in the same cycle, and it changes the published minimum when a wrapped sample is the lowest of its frame. A load counter that wraps, or that mishandles the load in the boundary cycle, appears at `load_count` one frame boundary later.

// File: rtl/wm_pkg.sv
package wm_pkg;
    localparam int unsigned FIELD_W = 16;

    typedef struct packed {
        logic [FIELD_W-1:0] line;
        logic [FIELD_W-1:0] level;
    } wm_status_t;

    localparam wm_status_t STATUS_RESET = '{line: '0, level: '1};
endpackage

// File: rtl/wm_level_calc.sv
module wm_level_calc #(
    parameter int unsigned PTR_W = 10
) (
    input  logic [PTR_W-1:0]          wr_pos,
    input  logic [PTR_W-1:0]          rd_pos,
    output logic [wm_pkg::FIELD_W-1:0] level,
    output logic                      empty
);
    logic [PTR_W-1:0] diff;

    always_comb begin
        diff              = wr_pos - rd_pos;
        level             = '0;
        level[PTR_W-1:0]  = diff;
        empty             = (diff == '0);
    end
endmodule

// File: rtl/wm_min_tracker.sv
module wm_min_tracker
    import wm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               sample_valid,
    input  logic [FIELD_W-1:0] level,
    input  logic [FIELD_W-1:0] line,
    output wm_status_t         status
);
    typedef struct packed {
        logic [FIELD_W-1:0] run_min;
        logic [FIELD_W-1:0] run_line;
        wm_status_t         pub;
    } trk_state_t;

    trk_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.pub.level = s_q.run_min;
            s_d.pub.line  = s_q.run_line;
            if (sample_valid) begin
                s_d.run_min  = level;
                s_d.run_line = line;
            end else begin
                s_d.run_min  = '1;
                s_d.run_line = '0;
            end
        end else if (sample_valid && (level < s_q.run_min)) begin
            s_d.run_min  = level;
            s_d.run_line = line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.run_min  <= '1;
            s_q.run_line <= '0;
            s_q.pub      <= STATUS_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.pub;

    // R3: within a frame the running minimum never rises
    assert_min_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (s_q.run_min <= $past(s_q.run_min)));

    // R5: a frame boundary publishes what was captured before it
    assert_publish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (status.level == $past(s_q.run_min)) && (status.line == $past(s_q.run_line)));

    // R7: an unqualified sample leaves the running search untouched
    assert_invalid_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !sample_valid) |=> $stable(s_q.run_min) && $stable(s_q.run_line));
endmodule

// File: rtl/wm_load_counter.sv
module wm_load_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             cache_load,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pub;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.pub = s_q.cnt;
            s_d.cnt = cache_load ? CNT_W'(1) : '0;
        end else if (cache_load && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.pub;

    // R9: a full counter stays full until the frame ends
    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && s_q.cnt == CNT_MAX) |=> (s_q.cnt == CNT_MAX));

    // R8: no load, no boundary, no count change
    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !cache_load) |=> $stable(s_q.cnt));
endmodule

// File: rtl/wm_tracker.sv
module wm_tracker #(
    parameter int unsigned PTR_W = 10,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             sample_valid,
    input  logic [PTR_W-1:0] wr_pos,
    input  logic [PTR_W-1:0] rd_pos,
    input  logic [15:0]      out_line,
    input  logic             cache_load,
    output logic [31:0]      run_status,
    output logic [CNT_W-1:0] load_count,
    output logic             stall
);
    import wm_pkg::*;

    logic [FIELD_W-1:0] level;
    logic               lvl_empty;
    wm_status_t         status;

    wm_level_calc #(.PTR_W(PTR_W)) u_level (
        .wr_pos (wr_pos),
        .rd_pos (rd_pos),
        .level  (level),
        .empty  (lvl_empty)
    );

    wm_min_tracker u_min (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .sample_valid (sample_valid),
        .level        (level),
        .line         (out_line),
        .status       (status)
    );

    wm_load_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cache_load  (cache_load),
        .count       (load_count)
    );

    assign run_status = status;
    assign stall      = lvl_empty;

    // R2: coinciding positions must raise the stall flag
    assert_stall_on_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pos == rd_pos) |-> stall);

    // R2: distinct positions must not raise it
    assert_no_false_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pos != rd_pos) |-> !stall);

    // R10: published outputs hold between frame boundaries
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(run_status) && $stable(load_count));
endmodule

// File: tb/sim_wm_tracker.sv
module sim_wm_tracker;
    localparam int unsigned PTR_W = 10;
    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             sample_valid = 1'b0;
    logic [PTR_W-1:0] wr_pos = '0;
    logic [PTR_W-1:0] rd_pos = '0;
    logic [15:0]      out_line = '0;
    logic             cache_load = 1'b0;
    logic [31:0]      run_status;
    logic [CNT_W-1:0] load_count;
    logic             stall;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wm_tracker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sample_valid(sample_valid), .wr_pos(wr_pos), .rd_pos(rd_pos),
        .out_line(out_line), .cache_load(cache_load),
        .run_status(run_status), .load_count(load_count), .stall(stall)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic fs, input logic v, input logic [PTR_W-1:0] w,
                       input logic [PTR_W-1:0] r, input logic [15:0] ln, input logic ld);
        frame_start = fs; sample_valid = v; wr_pos = w; rd_pos = r;
        out_line = ln; cache_load = ld;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0; sample_valid = 1'b0; cache_load = 1'b0;
    endtask

    task automatic t_reset;
        check("R10", "reset status", run_status, 32'h0000_FFFF);
        check("R10", "reset loads", 32'(load_count), 32'd0);
    endtask

    task automatic t_basic_min;
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 1, 50, 0, 1, 1);
        cyc(0, 1, 120, 100, 2, 1);
        cyc(0, 1, 30, 0, 3, 0);
        cyc(0, 1, 40, 20, 4, 1);
        cyc(1, 0, 0, 0, 0, 0);
        check("R3", "min level", 32'(run_status[15:0]), 32'd20);
        check("R4", "earliest tie line", 32'(run_status[31:16]), 32'd2);
        check("R8", "load count", 32'(load_count), 32'd3);
    endtask

    task automatic t_wrap;
        cyc(0, 1, 100, 0, 6, 0);
        cyc(0, 1, 5, 1020, 7, 0);
        cyc(0, 1, 1023, 1000, 8, 0);
        cyc(1, 0, 0, 0, 0, 0);
        check("R1", "wrapped level", run_status, 32'h0007_0009);
        check("R8", "no loads", 32'(load_count), 32'd0);
    endtask

    task automatic t_invalid_and_stall;
        wr_pos = 77; rd_pos = 77; sample_valid = 1'b0;
        #1;
        check("R2", "stall on equal", 32'(stall), 32'd1);
        cyc(0, 0, 77, 77, 9, 0);
        wr_pos = 78; rd_pos = 77;
        #1;
        check("R2", "no stall", 32'(stall), 32'd0);
        wr_pos = 3; rd_pos = 1000;
        #1;
        check("R2", "no stall on wrap", 32'(stall), 32'd0);
        cyc(0, 1, 78, 38, 10, 0);
        cyc(1, 1, 13, 10, 11, 1);
        check("R7", "invalid zero ignored", run_status, 32'h000A_0028);
    endtask

    task automatic t_boundary_sample;
        cyc(0, 1, 20, 10, 12, 1);
        cyc(1, 0, 0, 0, 0, 0);
        check("R5", "boundary sample kept", run_status, 32'h000B_0003);
        check("R5", "boundary load kept", 32'(load_count), 32'd2);
    endtask

    task automatic t_empty_and_zero;
        cyc(1, 0, 0, 0, 0, 0);
        check("R6", "empty frame", run_status, 32'h0000_FFFF);
        cyc(0, 1, 5, 5, 21, 0);
        cyc(0, 1, 9, 5, 22, 0);
        cyc(1, 0, 0, 0, 0, 0);
        check("R3", "zero level published", run_status, 32'h0015_0000);
    endtask

    task automatic t_hold;
        logic [31:0] st;
        logic [CNT_W-1:0] lc;
        st = run_status;
        lc = load_count;
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, PTR_W'(i), PTR_W'(i + 3), 16'(30 + i), 1);
            check("R10", "status held", run_status, st);
            check("R10", "count held", 32'(load_count), 32'(lc));
        end
    endtask

    task automatic t_saturate;
        cyc(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 0, 0);
        check("R9", "saturated count", 32'(load_count), 32'(255));
        cyc(0, 0, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 0, 0);
        check("R8", "restart after sat", 32'(load_count), 32'd1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_min();
        t_wrap();
        t_invalid_and_stall();
        t_boundary_sample();
        t_empty_and_zero();
        t_hold();
        t_saturate();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule